// File: doc/BRIEF.md
# Serial Receiver with Mute and Wakeup

This block receives asynchronous serial frames on one input line. Each frame has a start bit, `DATA_W` data bits sent least significant bit first, and one stop bit. The line is sampled on an oversampling tick that runs at `OVS` times the bit rate. Software uses a small register interface with three registers: control, status and data. Each kept frame loads the data register and raises a ready flag. An interrupt output follows the ready flag when interrupts are enabled.

Software can put the receiver into a mute state. While muted, every frame is dropped and the ready flag stays as it was. Hardware leaves the mute state by itself on one of two events, and a control bit selects which:
- an address frame, whose most significant data bit is 1;
- an idle line, meaning the line stays high for one whole frame time.

The mute bit is changed by a control write only when a separate qualifier bit is set in the same write. A hardware wakeup also beats a software set in the same cycle. So software can update the other control fields at any time without undoing a wakeup.

Top module: `uart_mute_rx`

Register map (`reg_addr`; reads are combinational):
- 0, control:
  - bit0 mute
  - bit1 wake select (1 = address frame, 0 = idle line)
  - bit2 interrupt enable
  - bit3 receiver enable
  - bit4 transmit enable (stored only)
  - bit5 break (stored only)
  - bit7 mute-write qualifier (write only, reads 0)
- 1, status: bit0 ready, bit1 mute, bit2 frame in progress.
- 2, data: the last kept frame in bits `DATA_W-1:0`.

## Requirements
- R1: After reset, the control, status and data registers all read 0 and `irq` is 0.
- R2: A frame starts on a low level seen on a tick. Each bit is decided by a majority of the samples at ticks `OVS/2-1`, `OVS/2` and `OVS/2+1` of that bit. The stop bit is decided the same way, and at that moment, if mute is 0, the data register takes the frame value and ready becomes 1.
- R3: If the majority of the start bit is 1, the frame is abandoned: no data is loaded, ready stays 0 and a later valid frame is received normally.
- R4: While mute is 1, a finished frame loads no data and leaves ready unchanged.
- R5: With wake select 1 and mute 1, a frame whose bit `DATA_W-1` is 1 clears mute before its stop bit is decided, so that frame is itself kept with ready 1. Frames with that bit 0 are dropped and leave mute set.
- R6: With wake select 0 and mute 1, the line staying high for `OVS*(DATA_W+2)` consecutive ticks clears mute, and the next frame is kept. Back-to-back frames do not clear mute.
- R7: A control write always updates bits 1 to 5. It changes mute to write-data bit0 only when write-data bit7 is 1 in the same write.
- R8: A hardware wakeup clears mute even when a qualified software write of 1 happens in the same cycle. A stale control value written back without the qualifier after an address wakeup does not set mute again, and the address frame is kept.
- R9: Reading the data register clears ready. A frame kept in the same cycle as that read leaves ready at 1.
- R10: `irq` is 1 exactly when ready is 1 and interrupt enable (control bit2) is 1.
- R11: With receiver enable 0, line activity produces no frame: ready stays 0 and status bit2 stays 0.
- R12: Status bit1 always shows the current mute value, and status bit2 is 1 while a frame is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, `OVS` pulses per bit time |
| rxd | input | 1 | Serial line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the data read side effect) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| rdy | output | 1 | Ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume a few things about the stimulus:
- `reg_wr` and `reg_rd` strobes are one cycle wide.
- `rxd` changes only in whole bit times of `OVS` ticks, apart from the deliberate short pulse that tests false starts.
- `tick` keeps a steady rate.

The stimulus holds `tick` high every cycle, so a bit lasts 16 clock cycles. It drives the line and register strobes only on falling clock edges, and it times the stale control write-back between the address bit decision and the stop bit decision. Random frames use random 9-bit values and random gaps, but every gap is at least a full stop bit, so frames never overlap.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

   typedef enum logic {
      RX_WAIT = 1'b0,
      RX_BUSY = 1'b1
   } rx_state_e;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   localparam int C_MUTE      = 0;
   localparam int C_WAKE_ADDR = 1;
   localparam int C_INT_EN    = 2;
   localparam int C_RX_EN     = 3;
   localparam int C_TX_EN     = 4;
   localparam int C_BRK       = 5;
   localparam int C_MUTE_QUAL = 7;

   localparam int S_RDY  = 0;
   localparam int S_MUTE = 1;
   localparam int S_BUSY = 2;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe <= '1;
            end else if (STAGES == 1) begin
               pipe <= din;
            end else begin
               pipe <= {pipe[STAGES-2:0], din};
            end
         end
         assign dout = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_mute_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              rx,
   output logic              busy,
   output logic              frame_done,
   output logic              addr_mark,
   output logic [DATA_W-1:0] data
);

   localparam int PW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W + 2);
   localparam logic [PW-1:0] P_S0   = PW'(OVS / 2 - 1);
   localparam logic [PW-1:0] P_S1   = PW'(OVS / 2);
   localparam logic [PW-1:0] P_S2   = PW'(OVS / 2 + 1);
   localparam logic [PW-1:0] P_LAST = PW'(OVS - 1);
   localparam logic [BW-1:0] B_MSB  = BW'(DATA_W);
   localparam logic [BW-1:0] B_STOP = BW'(DATA_W + 1);

   rx_state_e         state;
   logic [PW-1:0]     phase;
   logic [BW-1:0]     bit_idx;
   logic              smp0, smp1;
   logic              vote;
   logic [DATA_W-1:0] shreg;

   assign vote = (smp0 & smp1) | (smp0 & rx) | (smp1 & rx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= RX_WAIT;
         phase      <= '0;
         bit_idx    <= '0;
         smp0       <= 1'b1;
         smp1       <= 1'b1;
         shreg      <= '0;
         frame_done <= 1'b0;
         addr_mark  <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         addr_mark  <= 1'b0;
         if (!en) begin
            state <= RX_WAIT;
         end else if (tick) begin
            case (state)
               RX_WAIT: begin
                  if (!rx) begin
                     state   <= RX_BUSY;
                     phase   <= PW'(1);
                     bit_idx <= '0;
                  end
               end
               RX_BUSY: begin
                  if (phase == P_LAST) begin
                     phase   <= '0;
                     bit_idx <= bit_idx + BW'(1);
                  end else begin
                     phase <= phase + PW'(1);
                  end
                  if (phase == P_S0) smp0 <= rx;
                  if (phase == P_S1) smp1 <= rx;
                  if (phase == P_S2) begin
                     if (bit_idx == '0) begin
                        if (vote) state <= RX_WAIT;
                     end else if (bit_idx == B_STOP) begin
                        frame_done <= 1'b1;
                        state      <= RX_WAIT;
                     end else begin
                        for (int i = 0; i < DATA_W; i++) begin
                           if (bit_idx == BW'(i + 1)) shreg[i] <= vote;
                        end
                        if (bit_idx == B_MSB && vote) addr_mark <= 1'b1;
                     end
                  end
               end
               default: state <= RX_WAIT;
            endcase
         end
      end
   end

   assign busy = (state == RX_BUSY);
   assign data = shreg;

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
   parameter int LIMIT = 176
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic rx,
   output logic idle_pulse
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] C_MAX = CW'(LIMIT);

   logic [CW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len    <= '0;
         idle_pulse <= 1'b0;
      end else begin
         idle_pulse <= 1'b0;
         if (!en || !rx) begin
            run_len <= '0;
         end else if (tick && run_len != C_MAX) begin
            run_len <= run_len + CW'(1);
            if (run_len == C_MAX - CW'(1)) idle_pulse <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_mute_regs.sv
module uart_mute_regs
   import uart_mute_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              frame_done,
   input  logic              addr_mark,
   input  logic              idle_pulse,
   input  logic              busy,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rdy,
   output logic              irq,
   output logic              rx_en,
   output logic              mute,
   output logic              wake_addr
);

   logic              int_en, tx_en, brk;
   logic [DATA_W-1:0] data_q;
   logic              ctrl_wr, mute_wr, data_rd, wake_evt, keep;

   assign ctrl_wr  = reg_wr && reg_addr == A_CTRL;
   assign mute_wr  = ctrl_wr && reg_wdata[C_MUTE_QUAL];
   assign data_rd  = reg_rd && reg_addr == A_DATA;
   assign wake_evt = mute && (wake_addr ? addr_mark : idle_pulse);
   assign keep     = frame_done && !mute;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mute      <= 1'b0;
         wake_addr <= 1'b0;
         int_en    <= 1'b0;
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
         brk       <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            wake_addr <= reg_wdata[C_WAKE_ADDR];
            int_en    <= reg_wdata[C_INT_EN];
            rx_en     <= reg_wdata[C_RX_EN];
            tx_en     <= reg_wdata[C_TX_EN];
            brk       <= reg_wdata[C_BRK];
         end
         if (wake_evt) begin
            mute <= 1'b0;
         end else if (mute_wr) begin
            mute <= reg_wdata[C_MUTE];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy    <= 1'b0;
         data_q <= '0;
      end else begin
         if (keep) begin
            rdy    <= 1'b1;
            data_q <= rx_data;
         end else if (data_rd) begin
            rdy <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_MUTE]      = mute;
            reg_rdata[C_WAKE_ADDR] = wake_addr;
            reg_rdata[C_INT_EN]    = int_en;
            reg_rdata[C_RX_EN]     = rx_en;
            reg_rdata[C_TX_EN]     = tx_en;
            reg_rdata[C_BRK]       = brk;
         end
         A_STAT: begin
            reg_rdata[S_RDY]  = rdy;
            reg_rdata[S_MUTE] = mute;
            reg_rdata[S_BUSY] = busy;
         end
         A_DATA: reg_rdata[DATA_W-1:0] = data_q;
         default: reg_rdata = '0;
      endcase
   end

   assign irq = rdy & int_en;

endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx
   import uart_mute_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 9,
   parameter int REG_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rxd,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             rdy,
   output logic             irq
);

   localparam int IDLE_TICKS = OVS * (DATA_W + 2);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
         $error("DATA_W must lie between 5 and 9");
      end
      if (REG_W < 8 || REG_W < DATA_W) begin : g_bad_reg
         $error("REG_W must hold the data and control fields");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 3");
      end
   endgenerate

   logic              rx_s;
   logic              busy, frame_done, addr_mark, idle_pulse;
   logic              rx_en, mute, wake_addr, idle_en;
   logic [DATA_W-1:0] rx_data;

   assign idle_en = rx_en & mute & ~wake_addr;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rx_s)
   );

   uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .en        (rx_en),
      .rx        (rx_s),
      .busy      (busy),
      .frame_done(frame_done),
      .addr_mark (addr_mark),
      .data      (rx_data)
   );

   uart_rx_idle #(.LIMIT(IDLE_TICKS)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .en        (idle_en),
      .rx        (rx_s),
      .idle_pulse(idle_pulse)
   );

   uart_mute_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .frame_done(frame_done),
      .addr_mark (addr_mark),
      .idle_pulse(idle_pulse),
      .busy      (busy),
      .rx_data   (rx_data),
      .rdy       (rdy),
      .irq       (irq),
      .rx_en     (rx_en),
      .mute      (mute),
      .wake_addr (wake_addr)
   );

endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk #(
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [1:0]       reg_addr,
   input logic [REG_W-1:0] reg_wdata,
   input logic             frame_done,
   input logic             addr_mark,
   input logic             idle_pulse,
   input logic             mute,
   input logic             wake_addr,
   input logic             rdy
);

   logic data_rd, ctrl_wr, wake;
   assign data_rd = reg_rd && reg_addr == 2'd2;
   assign ctrl_wr = reg_wr && reg_addr == 2'd0;
   assign wake    = mute && (wake_addr ? addr_mark : idle_pulse);

   a_r2_keep_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && !mute |=> rdy);

   a_r4_muted_drop: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && mute && !data_rd |=> $stable(rdy));

   a_r8_wake_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !mute);

   a_r7_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !reg_wdata[7] && !wake |=> $stable(mute));

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !frame_done |=> !rdy);

endmodule

bind uart_mute_rx uart_mute_rx_chk #(.REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .frame_done(frame_done),
   .addr_mark (addr_mark),
   .idle_pulse(idle_pulse),
   .mute      (mute),
   .wake_addr (wake_addr),
   .rdy       (rdy)
);

// File: tb/tb_uart_mute_rx.sv
module tb_uart_mute_rx;

   localparam int OVS    = 16;
   localparam int DATA_W = 9;
   localparam int REG_W  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b1;
   logic             rxd = 1'b1;
   logic             reg_wr = 1'b0;
   logic             reg_rd = 1'b0;
   logic [1:0]       reg_addr = '0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             rdy, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_mute_rx #(.OVS(OVS), .DATA_W(DATA_W), .REG_W(REG_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rdy(rdy), .irq(irq)
   );

   function automatic logic [REG_W-1:0] ctrl_word(input bit mute, input bit wk,
         input bit ie, input bit re, input bit te, input bit bk, input bit qual);
      logic [REG_W-1:0] w = '0;
      w[0] = mute; w[1] = wk; w[2] = ie; w[3] = re; w[4] = te; w[5] = bk; w[7] = qual;
      return w;
   endfunction

   function automatic logic [REG_W-1:0] stat_word(input bit rd, input bit mute, input bit bsy);
      logic [REG_W-1:0] w = '0;
      w[0] = rd; w[1] = mute; w[2] = bsy;
      return w;
   endfunction

   task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send(input logic [DATA_W-1:0] d);
      @(negedge clk);
      rxd = 1'b0;
      repeat (OVS) @(negedge clk);
      for (int i = 0; i < DATA_W; i++) begin
         rxd = d[i];
         repeat (OVS) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (OVS) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [REG_W-1:0] v;
      logic [DATA_W-1:0] d;
      logic [REG_W-1:0] ce;
      void'($urandom(32'h5A17));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, '0);
      rd(2'd1, v); chk("R1 status", v, '0);
      rd(2'd2, v); chk("R1 data", v, '0);
      chk("R1 irq", {15'd0, irq}, 16'd0);

      // R11 receiver disabled
      send(9'h0A5);
      repeat (4) @(negedge clk);
      rd(2'd1, v); chk("R11 disabled status", v, stat_word(0, 0, 0));

      // R2 basic reception, R12 busy bit, R10 irq
      wr(2'd0, ctrl_word(0, 0, 1, 1, 0, 0, 0));
      rd(2'd0, v); chk("R7 ctrl fields written", v, ctrl_word(0, 0, 1, 1, 0, 0, 0));
      fork
         send(9'h13C);
         begin
            repeat (40) @(negedge clk);
            #1 chk("R12 busy mid frame", reg_rdata, stat_word(0, 0, 1));
         end
         begin
            @(negedge clk); reg_addr = 2'd1;
         end
      join
      rd(2'd1, v); chk("R2 ready after frame", v, stat_word(1, 0, 0));
      chk("R10 irq with enable", {15'd0, irq}, 16'd1);
      rd(2'd2, v); chk("R2 data value", v, 16'h013C);
      @(negedge clk);
      rd(2'd1, v); chk("R9 ready cleared by read", v, stat_word(0, 0, 0));
      chk("R10 irq low after read", {15'd0, irq}, 16'd0);

      // R10 irq masked
      wr(2'd0, ctrl_word(0, 0, 0, 1, 1, 1, 0));
      send(9'h0FF);
      repeat (2) @(negedge clk);
      chk("R10 irq masked", {15'd0, irq}, 16'd0);
      rd(2'd0, v); chk("R7 tx and break stored", v, ctrl_word(0, 0, 0, 1, 1, 1, 0));
      rd(2'd2, v); chk("R2 all ones frame", v, 16'h00FF);

      // R3 false start
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk); rxd = 1'b1;
      repeat (200) @(negedge clk);
      rd(2'd1, v); chk("R3 glitch dropped", v, stat_word(0, 0, 0));
      send(9'h055);
      rd(2'd2, v); chk("R3 next frame ok", v, 16'h0055);

      // R4, R5 address wakeup
      wr(2'd0, ctrl_word(1, 1, 0, 1, 0, 0, 1));
      rd(2'd1, v); chk("R12 mute mirror", v, stat_word(0, 1, 0));
      send(9'h0AA);
      rd(2'd1, v); chk("R4 data frame dropped", v, stat_word(0, 1, 0));
      send(9'h1C3);
      rd(2'd1, v); chk("R5 address frame kept", v, stat_word(1, 0, 0));
      rd(2'd2, v); chk("R5 address data", v, 16'h01C3);
      send(9'h022);
      rd(2'd2, v); chk("R5 following frame kept", v, 16'h0022);

      // R7 qualifier
      wr(2'd0, ctrl_word(1, 1, 0, 1, 0, 0, 1));
      wr(2'd0, ctrl_word(0, 1, 1, 1, 0, 0, 0));
      rd(2'd0, v); chk("R7 unqualified keeps mute", v, ctrl_word(1, 1, 1, 1, 0, 0, 0));
      wr(2'd0, ctrl_word(0, 1, 0, 1, 0, 0, 1));
      rd(2'd0, v); chk("R7 qualified clears mute", v, ctrl_word(0, 1, 0, 1, 0, 0, 0));

      // R8 stale write-back race
      wr(2'd0, ctrl_word(1, 1, 0, 1, 0, 0, 1));
      rd(2'd0, ce);
      chk("R8 stale copy has mute", ce, ctrl_word(1, 1, 0, 1, 0, 0, 0));
      fork
         send(9'h1E7);
         begin
            repeat (163) @(negedge clk);
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ce | 16'h0004;
            @(negedge clk);
            reg_wr = 1'b0;
         end
      join
      rd(2'd1, v); chk("R8 address frame not lost", v, stat_word(1, 0, 0));
      rd(2'd2, v); chk("R8 address data", v, 16'h01E7);
      rd(2'd0, v); chk("R8 other field updated", v, ctrl_word(0, 1, 1, 1, 0, 0, 0));

      // R6 idle wakeup
      wr(2'd0, ctrl_word(1, 0, 0, 1, 0, 0, 1));
      send(9'h111);
      send(9'h1F0);
      rd(2'd1, v); chk("R6 back-to-back stay muted", v, stat_word(0, 1, 0));
      repeat (200) @(negedge clk);
      rd(2'd1, v); chk("R6 idle cleared mute", v, stat_word(0, 0, 0));
      send(9'h066);
      rd(2'd2, v); chk("R6 next frame kept", v, 16'h0066);

      // R2 random frames
      wr(2'd0, ctrl_word(0, 0, 0, 1, 0, 0, 1));
      for (int n = 0; n < 24; n++) begin
         d = DATA_W'($urandom);
         send(d);
         rd(2'd2, v); chk("R2 random frame", v, REG_W'(d));
         repeat ($urandom % 20) @(negedge clk);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule